// File: doc/BRIEF.md
# Receiver error flag aggregator

This block gathers the error indications of a digital audio receiver into a single error output and a set of sticky status bits. It watches four error inputs. Loss of lock is a level. Parity, biphase and frame-length errors are qualified by a subframe strobe. It also detects a change in a 6-bit receiver status word. Two mask bits keep the data errors and the status-change flag away from the error output. Loss of lock always reaches the output.

After its last cause has gone, the error output stays high for a programmable number of sample periods. A status change counts as gone only when status register 1 is read. The sticky bits clear when status register 2 is read. The block also gates the audio sample path. On a data error it repeats the last error-free sample. While lock is lost it outputs zero.

Top module: `rx_err_flags`

## Requirements
- R1: On each subframe strobe with no error and lock present, `dout` takes the value of `din` one cycle later.
- R2: `err_out` is high whenever `unlock` is high and `pll_off` is low, regardless of both mask bits.
- R3: A parity, biphase or frame-length error on a subframe strobe drives `err_out` high only when `mask_data` is 1. It does so until the next subframe strobe.
- R4: On each `frame_tick`, `stat_word` is compared with its value at the previous `frame_tick`. A difference sets `stc_flag`. No difference leaves it unchanged.
- R5: `stc_flag` stays 0 for the first BLOCK_LEN frame ticks after reset, even if the word changes. It clears on `rd_stat1`, and a set in the same cycle wins. It drives `err_out` only when `mask_stc` is 1.
- R6: After all causes are gone, `err_out` stays high for exactly HOLD_BASE << `hold_sel` frame ticks and then falls. With HOLD_BASE = 512, `hold_sel` 00/01/10/11 gives 512/1024/2048/4096.
- R7: While `unlock` is high, `dout` is zero. A subframe strobe carrying a data error leaves `dout` at the last error-free sample.
- R8: The sticky bits `sticky_par`, `sticky_bip`, `sticky_len`, `sticky_v` and `sticky_unl` set on their condition and stay set until `rd_stat2`. A condition present in the read cycle keeps its bit set. The masks have no effect on the sticky bits.
- R9: `err_out` is low while `pll_off` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sub_tick | input | 1 | Subframe strobe qualifying errors, validity and din |
| frame_tick | input | 1 | Sample-period strobe |
| unlock | input | 1 | Loss-of-lock level |
| par_err | input | 1 | Parity error, valid with sub_tick |
| bip_err | input | 1 | Biphase error, valid with sub_tick |
| len_err | input | 1 | Frame-length error, valid with sub_tick |
| vbit | input | 1 | Validity bit, valid with sub_tick |
| din | input | W | Recovered sample |
| stat_word | input | 6 | Receiver status word |
| mask_data | input | 1 | 1 lets data errors reach err_out |
| mask_stc | input | 1 | 1 lets the status-change flag reach err_out |
| hold_sel | input | 2 | Hold length select |
| pll_off | input | 1 | Recovery PLL off; forces err_out low |
| rd_stat1 | input | 1 | Read strobe of status register 1 |
| rd_stat2 | input | 1 | Read strobe of status register 2 |
| dout | output | W | Gated sample output |
| err_out | output | 1 | Combined, stretched error output |
| stc_flag | output | 1 | Status-change flag |
| sticky_par | output | 1 | Sticky parity error |
| sticky_bip | output | 1 | Sticky biphase error |
| sticky_len | output | 1 | Sticky frame-length error |
| sticky_v | output | 1 | Sticky validity bit |
| sticky_unl | output | 1 | Sticky loss of lock |

## Verification
The bench builds the block with W = 8, HOLD_BASE = 4 and BLOCK_LEN = 6. This brings all four hold settings (4, 8, 16 and 32 frame ticks) within reach, and each is swept and counted tick by tick to the exact falling edge. The short block length puts the end of the status-change suppression window a few ticks after reset, so both its last suppressed tick and its first active tick are checked.

// File: rtl/rx_err_flags.sv
module rx_err_flags #(
  parameter int W = 24,
  parameter int HOLD_BASE = 512,
  parameter int BLOCK_LEN = 192
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         sub_tick,
  input  logic         frame_tick,
  input  logic         unlock,
  input  logic         par_err,
  input  logic         bip_err,
  input  logic         len_err,
  input  logic         vbit,
  input  logic [W-1:0] din,
  input  logic [5:0]   stat_word,
  input  logic         mask_data,
  input  logic         mask_stc,
  input  logic [1:0]   hold_sel,
  input  logic         pll_off,
  input  logic         rd_stat1,
  input  logic         rd_stat2,
  output logic [W-1:0] dout,
  output logic         err_out,
  output logic         stc_flag,
  output logic         sticky_par,
  output logic         sticky_bip,
  output logic         sticky_len,
  output logic         sticky_v,
  output logic         sticky_unl
);
  localparam int HW = $clog2(HOLD_BASE * 8 + 1);
  localparam int BW = $clog2(BLOCK_LEN + 1);

  logic [W-1:0]  good_q;
  logic          derr_q;
  logic [5:0]    prev_word;
  logic [BW-1:0] blk_cnt;
  logic [HW-1:0] hold_cnt;
  logic          armed, cause, any_derr;
  logic [HW-1:0] hold_len;

  assign any_derr = par_err | bip_err | len_err;
  assign armed    = (blk_cnt == BW'(BLOCK_LEN));
  assign hold_len = HW'(HOLD_BASE) << hold_sel;
  assign cause    = unlock | (mask_data & derr_q) | (mask_stc & stc_flag);
  assign err_out  = ~pll_off & (cause | (hold_cnt != '0));
  assign dout     = unlock ? '0 : good_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      good_q <= '0;
      derr_q <= 1'b0;
    end else if (sub_tick) begin
      derr_q <= any_derr;
      if (!unlock && !any_derr) good_q <= din;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_word <= '0;
      blk_cnt   <= '0;
      stc_flag  <= 1'b0;
    end else begin
      if (frame_tick) begin
        prev_word <= stat_word;
        if (!armed) blk_cnt <= blk_cnt + 1'b1;
      end
      if (frame_tick && armed && (stat_word != prev_word)) stc_flag <= 1'b1;
      else if (rd_stat1)                                     stc_flag <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                           hold_cnt <= '0;
    else if (cause)                       hold_cnt <= hold_len;
    else if (frame_tick && hold_cnt != '0) hold_cnt <= hold_cnt - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sticky_par <= 1'b0;
      sticky_bip <= 1'b0;
      sticky_len <= 1'b0;
      sticky_v   <= 1'b0;
      sticky_unl <= 1'b0;
    end else begin
      sticky_par <= (sub_tick & par_err) | (sticky_par & ~rd_stat2);
      sticky_bip <= (sub_tick & bip_err) | (sticky_bip & ~rd_stat2);
      sticky_len <= (sub_tick & len_err) | (sticky_len & ~rd_stat2);
      sticky_v   <= (sub_tick & vbit)    | (sticky_v   & ~rd_stat2);
      sticky_unl <= unlock               | (sticky_unl & ~rd_stat2);
    end
  end
endmodule

module rx_err_flags_chk #(
  parameter int W = 24
) (
  input logic         clk,
  input logic         rst_n,
  input logic         sub_tick,
  input logic         frame_tick,
  input logic         unlock,
  input logic         par_err,
  input logic         bip_err,
  input logic         len_err,
  input logic         pll_off,
  input logic         rd_stat1,
  input logic         rd_stat2,
  input logic [W-1:0] dout,
  input logic         err_out,
  input logic         stc_flag,
  input logic         sticky_par,
  input logic         sticky_unl
);
  a_r2_unlock_unmaskable: assert property (@(posedge clk) disable iff (!rst_n)
    (unlock && !pll_off) |-> err_out);
  a_r9_pll_off_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    pll_off |-> !err_out);
  a_r7_unlock_zero: assert property (@(posedge clk) disable iff (!rst_n)
    unlock |-> (dout == '0));
  a_r7_repeat_last: assert property (@(posedge clk) disable iff (!rst_n)
    (!unlock && $past(!unlock && sub_tick && (par_err || bip_err || len_err)))
      |-> (dout == $past(dout)));
  a_r8_unlock_sticks: assert property (@(posedge clk) disable iff (!rst_n)
    unlock |=> sticky_unl);
  a_r8_par_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (sticky_par && !rd_stat2) |=> sticky_par);
  a_r5_stc_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stat1 && !frame_tick) |=> !stc_flag);
  a_r4_stc_only_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (!frame_tick && !stc_flag) |=> !stc_flag);
endmodule

bind rx_err_flags rx_err_flags_chk #(.W(W)) chk_i (
  .clk(clk), .rst_n(rst_n), .sub_tick(sub_tick), .frame_tick(frame_tick),
  .unlock(unlock), .par_err(par_err), .bip_err(bip_err), .len_err(len_err),
  .pll_off(pll_off), .rd_stat1(rd_stat1), .rd_stat2(rd_stat2), .dout(dout),
  .err_out(err_out), .stc_flag(stc_flag), .sticky_par(sticky_par),
  .sticky_unl(sticky_unl)
);

// File: tb/rx_err_flags_test.sv
`timescale 1ns/1ps
module rx_err_flags_test;
  localparam int W = 8;
  localparam int HB = 4;
  localparam int BL = 6;

  logic clk = 0;
  logic rst_n = 0;
  logic sub_tick = 0, frame_tick = 0, unlock = 0;
  logic par_err = 0, bip_err = 0, len_err = 0, vbit = 0;
  logic [W-1:0] din = '0;
  logic [5:0] stat_word = '0;
  logic mask_data = 1, mask_stc = 1, pll_off = 0;
  logic [1:0] hold_sel = 2'b01;
  logic rd_stat1 = 0, rd_stat2 = 0;
  logic [W-1:0] dout;
  logic err_out, stc_flag, sticky_par, sticky_bip, sticky_len, sticky_v, sticky_unl;

  int checks = 0, fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  rx_err_flags #(.W(W), .HOLD_BASE(HB), .BLOCK_LEN(BL)) uut (
    .clk(clk), .rst_n(rst_n), .sub_tick(sub_tick), .frame_tick(frame_tick),
    .unlock(unlock), .par_err(par_err), .bip_err(bip_err), .len_err(len_err),
    .vbit(vbit), .din(din), .stat_word(stat_word), .mask_data(mask_data),
    .mask_stc(mask_stc), .hold_sel(hold_sel), .pll_off(pll_off),
    .rd_stat1(rd_stat1), .rd_stat2(rd_stat2), .dout(dout), .err_out(err_out),
    .stc_flag(stc_flag), .sticky_par(sticky_par), .sticky_bip(sticky_bip),
    .sticky_len(sticky_len), .sticky_v(sticky_v), .sticky_unl(sticky_unl));

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
    sub_tick = 0; frame_tick = 0; par_err = 0; bip_err = 0; len_err = 0;
    vbit = 0; rd_stat1 = 0; rd_stat2 = 0;
  endtask

  task automatic do_reset();
    rst_n = 0;
    repeat (3) step();
    rst_n = 1;
    step();
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #200000;
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    do_reset();
    chk(err_out, 0, "reset err_out");
    chk(dout, 0, "reset dout");
    chk({sticky_par, sticky_bip, sticky_len, sticky_v, sticky_unl, stc_flag}, 0, "reset flags");

    // R1 pass-through sweep
    for (int k = 0; k < 256; k += 17) begin
      sub_tick = 1; din = W'(k);
      step();
      chk(dout, k, "R1 pass-through");
    end
    chk(err_out, 0, "R1 clean err_out");

    // R7 repeat last good sample, R3 data error reported, R8 sticky bits
    din = 8'hA5; sub_tick = 1; step();
    din = 8'h3C; sub_tick = 1; par_err = 1; step();
    chk(dout, 8'hA5, "R7 parity repeat");
    chk(err_out, 1, "R3 parity err_out");
    din = 8'h3D; sub_tick = 1; bip_err = 1; vbit = 1; step();
    chk(dout, 8'hA5, "R7 biphase repeat");
    din = 8'h3E; sub_tick = 1; len_err = 1; step();
    chk(dout, 8'hA5, "R7 length repeat");
    chk({sticky_par, sticky_bip, sticky_len, sticky_v}, 4'hF, "R8 sticky set");

    // R6 hold sweep over all selections
    for (int s = 0; s < 4; s++) begin
      hold_sel = 2'(s);
      sub_tick = 1; par_err = 1; din = 8'h11; step();
      sub_tick = 1; din = 8'h22; step();
      chk(dout, 8'h22, "R1 recovery");
      for (int t = 1; t <= (HB << s); t++) begin
        frame_tick = 1; step();
        chk(err_out, (t < (HB << s)) ? 1 : 0, $sformatf("R6 hold sel%0d tick%0d", s, t));
      end
    end

    // R8 read clears sticky; set wins
    rd_stat2 = 1; sub_tick = 1; par_err = 1; step();
    chk(sticky_par, 1, "R8 set wins over read");
    chk({sticky_bip, sticky_len, sticky_v}, 0, "R8 read clears");
    rd_stat2 = 1; step();
    chk(sticky_par, 0, "R8 read clears par");
    sub_tick = 1; din = 8'h22; step();
    repeat (40) begin frame_tick = 1; step(); end
    chk(err_out, 0, "R6 idle before mask test");

    // R3 masked data errors, sticky still set
    mask_data = 0;
    sub_tick = 1; len_err = 1; din = 8'h77; step();
    chk(err_out, 0, "R3 masked err_out");
    chk(sticky_len, 1, "R8 sticky ignores mask");
    chk(dout, 8'h22, "R7 repeat while masked");
    sub_tick = 1; din = 8'h23; step();

    // R2 unlock unmaskable, R7 zero output
    mask_stc = 0;
    unlock = 1; step();
    chk(err_out, 1, "R2 unlock err_out");
    chk(dout, 0, "R7 unlock zero");
    chk(sticky_unl, 1, "R8 sticky unlock");
    rd_stat2 = 1; step();
    chk(sticky_unl, 1, "R8 unlock set wins");
    // R9 pll off forces low
    pll_off = 1; step();
    chk(err_out, 0, "R9 pll off");
    pll_off = 0; unlock = 0; step();
    chk(dout, 8'h23, "R7 after unlock");
    mask_data = 1; mask_stc = 1;

    // R5 suppression window and R4 change detection
    do_reset();
    hold_sel = 2'b00;
    for (int t = 1; t <= BL; t++) begin
      stat_word = 6'(t * 5); frame_tick = 1; step();
      chk(stc_flag, 0, $sformatf("R5 suppressed tick%0d", t));
    end
    frame_tick = 1; step();
    chk(stc_flag, 0, "R4 no change");
    stat_word = 6'h2A; frame_tick = 1; step();
    chk(stc_flag, 1, "R4 change detected");
    chk(err_out, 1, "R5 stc reported");
    repeat (8) begin frame_tick = 1; step(); end
    chk(err_out, 1, "R6 stc holds until read");
    rd_stat1 = 1; step();
    chk(stc_flag, 0, "R5 read clears");
    chk(err_out, 1, "R6 hold after read");
    for (int t = 1; t <= HB; t++) begin
      frame_tick = 1; step();
      chk(err_out, (t < HB) ? 1 : 0, $sformatf("R6 stc hold tick%0d", t));
    end
    rd_stat1 = 1; stat_word = 6'h15; frame_tick = 1; step();
    chk(stc_flag, 1, "R5 set wins over read");
    mask_stc = 0; rd_stat1 = 1; step();
    repeat (HB + 1) begin frame_tick = 1; step(); end
    stat_word = 6'h01; frame_tick = 1; step();
    chk(stc_flag, 1, "R4 masked flag set");
    chk(err_out, 0, "R5 mask hides stc");

    finish_run();
  end
endmodule